// File: doc/BRIEF.md
# Nibble Accumulator Processor

This block is a compact processor built around a 4-bit datapath. It has four 4-bit general registers, and register 0 serves as the accumulator. Instructions are made of 4-bit words held in an external memory with an 8-bit address. The first word is the opcode, and the opcode decides whether zero, one or two operand words follow it. When two operand words follow, they form an 8-bit address: the first gives the upper nibble and the second gives the lower nibble. That address is used by the load, the store and the conditional jump.

The core keeps an 8-bit program counter, an 8-bit memory address register and three opcode/operand word registers. A small control sequencer repeats the same pattern for every word. It copies the program counter into the address register and advances the counter. It then issues a read and holds it until the memory stops stalling. Finally it latches the returned word. Once the last word of an instruction is in, the instruction executes in one decide cycle, or in one extra memory access for a load or a store. The sequencer then returns to fetching.

Top module: `nibble_cpu`

## Requirements
- R1: While rst_n is low, mem_req stays low and the program counter and all four registers are cleared. After release, the first request is a read (mem_rw=1) at address 0x00.
- R2: A transfer completes on the rising clock edge at which mem_req is high and mem_wait is low. While mem_wait is high, the request, mem_rw and mem_addr hold steady, and each transfer completes exactly once.
- R3: Opcodes whose upper two bits are not 11 are one word long. Opcode 1100 is two words long, and opcodes 1101, 1110 and 1111 are three words long. The words are read from consecutive addresses, and each read advances the program counter by one, wrapping modulo 256.
- R4: Opcode 00ss sets R0 to R0 + R[ss] modulo 16. Opcode 01ss sets R0 to R0 AND R[ss]. In both, ss is the low two bits of the opcode.
- R5: Opcode 1000 replaces R0 with its bitwise complement. Opcode 1001 adds one to R0 modulo 16, so 0xF becomes 0x0.
- R6: Opcode 1010 rotates R1 right by one bit, and its bit 0 moves to bit 3. Opcode 1011 shifts R1 right by one bit and keeps bit 3 unchanged.
- R7: Opcode 1100 with operand word dddsss, written as bits [3:2]=d and bits [1:0]=s, copies R[s] into R[d].
- R8: Opcode 1101 with operand words hi and lo reads address {hi,lo} and places the word read into R0.
- R9: Opcode 1110 with operand words hi and lo writes R0 to address {hi,lo} with mem_rw=0. That is the only write the processor makes.
- R10: Opcode 1111 with operand words hi and lo sets the program counter to {hi,lo} when bit 3 of R0 is 1. Otherwise execution continues at the word right after lo.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_req | output | 1 | Memory access request |
| mem_rw | output | 1 | Access type: 1 read, 0 write |
| mem_addr | output | 8 | Memory word address |
| mem_wdata | output | 4 | Write data (value of R0) |
| mem_rdata | input | 4 | Read data returned by memory |
| mem_wait | input | 1 | Memory stall; the access is held while high |

## Verification
The bench drives a stalling memory model. A core that latched data before the stall ended, or that moved its address during a stall, would load the wrong word or double-count transfers. The program streams mix one-, two- and three-word instructions. A wrong word count would therefore decode operand nibbles as opcodes and corrupt every stored result. The corner cases covered are increment from 0xF wrapping to 0, rotate versus arithmetic shift on values with bit 3 set and clear, and branches both taken and not taken. A not-taken branch that skipped the wrong distance would lose the following store, and a taken one would fetch from the fall-through address that the bench marks as forbidden. A final run after reset stores R0 and R3, which exposes registers that kept their contents across reset.

// File: rtl/nibble_cpu_pkg.sv
package nibble_cpu_pkg;

   typedef enum logic [1:0] {
      CS_FADDR,
      CS_FREAD,
      CS_DECIDE,
      CS_DACC
   } cpu_state_e;

   typedef enum logic [2:0] {
      AL_ADD,
      AL_AND,
      AL_NOT,
      AL_INC,
      AL_ROR,
      AL_ASR
   } alu_op_e;

   // opcode group in bits [3:2]
   localparam logic [1:0] GRP_ADD   = 2'b00;
   localparam logic [1:0] GRP_AND   = 2'b01;
   localparam logic [1:0] GRP_UNARY = 2'b10;
   localparam logic [1:0] GRP_LONG  = 2'b11;

   // long-group selector in bits [1:0]
   localparam logic [1:0] LG_XFER   = 2'b00;
   localparam logic [1:0] LG_LOAD   = 2'b01;
   localparam logic [1:0] LG_STORE  = 2'b10;
   localparam logic [1:0] LG_BRANCH = 2'b11;

   function automatic logic [1:0] words_for(input logic [3:0] opc);
      if (opc[3:2] != GRP_LONG)      return 2'd1;
      else if (opc[1:0] == LG_XFER)  return 2'd2;
      else                           return 2'd3;
   endfunction

endpackage

// File: rtl/nc_alu.sv
module nc_alu
   import nibble_cpu_pkg::*;
#(
   parameter int DW = 4
) (
   input  alu_op_e       op,
   input  logic [DW-1:0] acc,
   input  logic [DW-1:0] opnd,
   input  logic [DW-1:0] sreg,
   output logic [DW-1:0] res
);

   always_comb begin
      unique case (op)
         AL_ADD:  res = acc + opnd;
         AL_AND:  res = acc & opnd;
         AL_NOT:  res = ~acc;
         AL_INC:  res = acc + DW'(1);
         AL_ROR:  res = {sreg[0], sreg[DW-1:1]};
         AL_ASR:  res = {sreg[DW-1], sreg[DW-1:1]};
         default: res = acc;
      endcase
   end

endmodule

// File: rtl/nc_regfile.sv
module nc_regfile #(
   parameter int DW        = 4,
   parameter int NREG      = 4,
   parameter bit CLEAR_RST = 1'b1,
   localparam int IW       = $clog2(NREG)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [IW-1:0] wr_idx,
   input  logic [DW-1:0] wr_data,
   input  logic [IW-1:0] rd_idx,
   output logic [DW-1:0] rd_data,
   output logic [DW-1:0] acc,
   output logic [DW-1:0] sreg
);

   logic [DW-1:0] regs [NREG];

   for (genvar g = 0; g < NREG; g++) begin : g_reg
      logic [DW-1:0] q;
      logic          hit;
      assign hit = wr_en && (wr_idx == IW'(g));
      if (CLEAR_RST) begin : g_clr
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   q <= '0;
            else if (hit) q <= wr_data;
         end
      end else begin : g_keep
         always_ff @(posedge clk) begin
            if (hit) q <= wr_data;
         end
      end
      assign regs[g] = q;
   end

   assign rd_data = regs[rd_idx];
   assign acc     = regs[0];
   assign sreg    = regs[1];

endmodule

// File: rtl/nc_ctrl.sv
module nc_ctrl
   import nibble_cpu_pkg::*;
#(
   parameter int DW = 4,
   parameter int AW = 8,
   parameter int IW = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   output logic          mem_req,
   output logic          mem_rw,
   output logic [AW-1:0] mem_addr,
   output logic [DW-1:0] mem_wdata,
   input  logic [DW-1:0] mem_rdata,
   input  logic          mem_wait,
   input  logic [DW-1:0] acc,
   input  logic [DW-1:0] rd_data,
   input  logic [DW-1:0] alu_res,
   output alu_op_e       alu_op,
   output logic [IW-1:0] rd_idx,
   output logic          wr_en,
   output logic [IW-1:0] wr_idx,
   output logic [DW-1:0] wr_data,
   output logic [DW-1:0] ir1_o,
   output logic [DW-1:0] ir2_o
);

   cpu_state_e    state_q;
   logic [AW-1:0] pc_q, mar_q;
   logic [DW-1:0] ir0_q, ir1_q, ir2_q;
   logic [1:0]    widx_q;
   logic          last_word;
   logic [AW-1:0] op_addr;

   assign last_word = (2'(widx_q + 2'd1) == words_for(ir0_q[3:0]));
   assign op_addr   = {ir1_q, ir2_q};
   assign ir1_o     = ir1_q;
   assign ir2_o     = ir2_q;

   assign mem_req   = (state_q == CS_FREAD) || (state_q == CS_DACC);
   assign mem_rw    = !((state_q == CS_DACC) && (ir0_q[1:0] == LG_STORE));
   assign mem_addr  = mar_q;
   assign mem_wdata = acc;

   assign rd_idx = (ir0_q[3:2] == GRP_LONG) ? IW'(ir1_q[1:0]) : IW'(ir0_q[1:0]);

   always_comb begin
      unique case (ir0_q[3:2])
         GRP_ADD: alu_op = AL_ADD;
         GRP_AND: alu_op = AL_AND;
         GRP_UNARY: begin
            unique case (ir0_q[1:0])
               2'b00:   alu_op = AL_NOT;
               2'b01:   alu_op = AL_INC;
               2'b10:   alu_op = AL_ROR;
               default: alu_op = AL_ASR;
            endcase
         end
         default: alu_op = AL_ADD;
      endcase
   end

   always_comb begin
      wr_en   = 1'b0;
      wr_idx  = '0;
      wr_data = alu_res;
      if (state_q == CS_DECIDE && last_word) begin
         unique case (ir0_q[3:2])
            GRP_ADD, GRP_AND: wr_en = 1'b1;
            GRP_UNARY: begin
               wr_en  = 1'b1;
               wr_idx = ir0_q[1] ? IW'(1) : IW'(0);
            end
            default: begin
               if (ir0_q[1:0] == LG_XFER) begin
                  wr_en   = 1'b1;
                  wr_idx  = IW'(ir1_q[3:2]);
                  wr_data = rd_data;
               end
            end
         endcase
      end else if (state_q == CS_DACC && !mem_wait && ir0_q[1:0] == LG_LOAD) begin
         wr_en   = 1'b1;
         wr_data = mem_rdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= CS_FADDR;
         pc_q    <= '0;
         mar_q   <= '0;
         ir0_q   <= '0;
         ir1_q   <= '0;
         ir2_q   <= '0;
         widx_q  <= '0;
      end else begin
         unique case (state_q)
            CS_FADDR: begin
               mar_q   <= pc_q;
               pc_q    <= pc_q + AW'(1);
               state_q <= CS_FREAD;
            end
            CS_FREAD: begin
               if (!mem_wait) begin
                  unique case (widx_q)
                     2'd0:    ir0_q <= mem_rdata;
                     2'd1:    ir1_q <= mem_rdata;
                     default: ir2_q <= mem_rdata;
                  endcase
                  state_q <= CS_DECIDE;
               end
            end
            CS_DECIDE: begin
               state_q <= CS_FADDR;
               if (!last_word) begin
                  widx_q <= widx_q + 2'd1;
               end else begin
                  widx_q <= '0;
                  if (ir0_q[3:2] == GRP_LONG) begin
                     unique case (ir0_q[1:0])
                        LG_LOAD, LG_STORE: begin
                           mar_q   <= op_addr;
                           state_q <= CS_DACC;
                        end
                        LG_BRANCH: if (acc[DW-1]) pc_q <= op_addr;
                        default: ;
                     endcase
                  end
               end
            end
            default: begin
               if (!mem_wait) state_q <= CS_FADDR;
            end
         endcase
      end
   end

endmodule

// File: rtl/nibble_cpu.sv
module nibble_cpu
   import nibble_cpu_pkg::*;
#(
   parameter int DATA_W     = 4,
   parameter int ADDR_W     = 8,
   parameter int NUM_REGS   = 4,
   parameter bit CLEAR_REGS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic              mem_req,
   output logic              mem_rw,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic              mem_wait
);

   localparam int IW = $clog2(NUM_REGS);

   if (DATA_W != 4) begin : g_bad_dw
      $error("nibble_cpu: instruction encoding needs DATA_W == 4");
   end
   if (ADDR_W != 2 * DATA_W) begin : g_bad_aw
      $error("nibble_cpu: ADDR_W must be two operand words");
   end
   if (NUM_REGS != 4) begin : g_bad_nr
      $error("nibble_cpu: register fields are two bits wide");
   end

   alu_op_e           alu_op;
   logic [IW-1:0]     rd_idx, wr_idx;
   logic              wr_en;
   logic [DATA_W-1:0] wr_data, rd_data, acc, sreg, alu_res;
   logic [DATA_W-1:0] ir1_w, ir2_w;

   nc_regfile #(.DW(DATA_W), .NREG(NUM_REGS), .CLEAR_RST(CLEAR_REGS)) u_rf (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_idx  (wr_idx),
      .wr_data (wr_data),
      .rd_idx  (rd_idx),
      .rd_data (rd_data),
      .acc     (acc),
      .sreg    (sreg)
   );

   nc_alu #(.DW(DATA_W)) u_alu (
      .op   (alu_op),
      .acc  (acc),
      .opnd (rd_data),
      .sreg (sreg),
      .res  (alu_res)
   );

   nc_ctrl #(.DW(DATA_W), .AW(ADDR_W), .IW(IW)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .mem_req   (mem_req),
      .mem_rw    (mem_rw),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata),
      .mem_rdata (mem_rdata),
      .mem_wait  (mem_wait),
      .acc       (acc),
      .rd_data   (rd_data),
      .alu_res   (alu_res),
      .alu_op    (alu_op),
      .rd_idx    (rd_idx),
      .wr_en     (wr_en),
      .wr_idx    (wr_idx),
      .wr_data   (wr_data),
      .ir1_o     (ir1_w),
      .ir2_o     (ir2_w)
   );

endmodule

// File: rtl/nibble_cpu_chk.sv
module nibble_cpu_chk #(
   parameter int DW = 4,
   parameter int AW = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          mem_req,
   input logic          mem_rw,
   input logic          mem_wait,
   input logic [AW-1:0] mem_addr,
   input logic [DW-1:0] ir1,
   input logic [DW-1:0] ir2
);

   // R1
   always @(posedge clk) begin
      if (!rst_n) begin
         idle_in_reset_chk: assert (!mem_req);
      end
   end

   // R2
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_wait |=> mem_req && $stable(mem_addr) && $stable(mem_rw));

   // R2
   one_shot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_wait |=> !mem_req);

   // R9
   store_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_rw |-> mem_addr == {ir1, ir2});

endmodule

bind nibble_cpu nibble_cpu_chk #(.DW(DATA_W), .AW(ADDR_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .mem_req  (mem_req),
   .mem_rw   (mem_rw),
   .mem_wait (mem_wait),
   .mem_addr (mem_addr),
   .ir1      (ir1_w),
   .ir2      (ir2_w)
);

// File: tb/sim_nibble_cpu.sv
`timescale 1ns/1ps
module sim_nibble_cpu;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       mem_req, mem_rw, mem_wait;
   logic [7:0] mem_addr;
   logic [3:0] mem_wdata, mem_rdata;

   always #5 clk = ~clk;

   nibble_cpu u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .mem_req   (mem_req),
      .mem_rw    (mem_rw),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata),
      .mem_rdata (mem_rdata),
      .mem_wait  (mem_wait)
   );

   logic [3:0] mem [256];
   logic [3:0] img [256];
   logic [8:0] log_q [64];
   int         log_n, n_writes, wcnt, lat;
   logic       bad_fetch;
   logic [7:0] bad_a = 8'hFF, bad_b = 8'hFF;
   int         checks = 0, errors = 0;

   assign mem_wait  = mem_req && (wcnt < lat);
   assign mem_rdata = mem[mem_addr];

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 256; i++) mem[i] <= img[i];
         wcnt      <= 0;
         log_n     <= 0;
         n_writes  <= 0;
         bad_fetch <= 1'b0;
      end else begin
         if (mem_req && mem_wait) wcnt <= wcnt + 1;
         else                     wcnt <= 0;
         if (mem_req && !mem_wait) begin
            if (log_n < 64) log_q[log_n] <= {mem_rw, mem_addr};
            log_n <= log_n + 1;
            if (!mem_rw) begin
               mem[mem_addr] <= mem_wdata;
               n_writes      <= n_writes + 1;
            end
            if (mem_rw && (mem_addr == bad_a || mem_addr == bad_b)) bad_fetch <= 1'b1;
         end
      end
   end

   task automatic check(input string tag, input logic [11:0] got, input logic [11:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", tag, got, exp);
      end
   endtask

   task automatic start(input int l);
      @(negedge clk);
      rst_n = 1'b0;
      lat   = l;
      bad_a = 8'hFF;
      bad_b = 8'hFF;
      for (int i = 0; i < 256; i++) img[i] = 4'h0;
   endtask

   task automatic load(input int base, input logic [63:0] h, input int n);
      for (int i = 0; i < n; i++) img[base + i] = h[4*(n-1-i) +: 4];
   endtask

   task automatic run(input logic [7:0] end_a);
      int n = 0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      while (!(mem_req && mem_rw && mem_addr == end_a) && n < 3000) begin
         @(negedge clk);
         n++;
      end
      if (n >= 3000) begin
         checks++;
         errors++;
         $display("FAIL run actual timeout expected fetch at %h", end_a);
      end
   endtask

   task automatic t_reset();
      int n = 0;
      start(0);
      load(0, 64'h9, 1);
      repeat (3) begin
         @(negedge clk);
         check("R1 no request in reset", 12'(mem_req), 12'h0);
      end
      rst_n = 1'b1;
      while (!mem_req && n < 10) begin
         @(negedge clk);
         n++;
      end
      check("R1 first address", 12'(mem_addr), 12'h000);
      check("R1 first access is read", 12'(mem_rw), 12'h1);
   endtask

   task automatic t_ldst_wait();
      start(3);
      img[8'h80] = 4'h5;
      load(0, 64'hD80E90, 6);
      run(8'h06);
      check("R8 R9 stored value", 12'(mem[8'h90]), 12'h5);
      check("R9 single write", 12'(n_writes), 12'h1);
      check("R2 one completion per access", 12'(log_n), 12'h8);
      check("R3 third word address", 12'(log_q[2]), 12'h102);
      check("R8 data read address", 12'(log_q[3]), 12'h180);
      check("R3 next opcode address", 12'(log_q[4]), 12'h103);
      check("R9 write access", 12'(log_q[7]), 12'h090);
   endtask

   task automatic t_arith();
      start(0);
      img[8'h80] = 4'h9;
      img[8'h81] = 4'hA;
      img[8'h82] = 4'hF;
      load(0, 64'hD80C4D811E909E91, 16);
      load(16, 64'hD829E92, 7);
      run(8'h17);
      check("R4 add wraps", 12'(mem[8'h90]), 12'h3);
      check("R5 increment", 12'(mem[8'h91]), 12'h4);
      check("R5 increment F wraps", 12'(mem[8'h92]), 12'h0);
   endtask

   task automatic t_logic();
      start(1);
      img[8'h80] = 4'hC;
      img[8'h81] = 4'hA;
      load(0, 64'hD80C8D816E908E91, 16);
      run(8'h10);
      check("R4 and with R2", 12'(mem[8'h90]), 12'h8);
      check("R5 complement", 12'(mem[8'h91]), 12'h7);
   endtask

   task automatic t_shift();
      start(2);
      img[8'h80] = 4'h9;
      img[8'h81] = 4'h6;
      load(0, 64'hD80C4AC1E90BC1E9, 16);
      load(16, 64'h1D81C4BC1E92, 12);
      run(8'h1C);
      check("R6 rotate right", 12'(mem[8'h90]), 12'hC);
      check("R6 arith shift negative", 12'(mem[8'h91]), 12'hE);
      check("R6 arith shift positive", 12'(mem[8'h92]), 12'h3);
      check("R7 transfer count of writes", 12'(n_writes), 12'h3);
   endtask

   task automatic t_branch();
      start(1);
      img[8'h80] = 4'h8;
      img[8'h81] = 4'h7;
      load(0, 64'hD81F50E91D80F40, 15);
      load(8'h40, 64'hE90, 3);
      bad_a = 8'h50;
      bad_b = 8'h0F;
      run(8'h43);
      check("R10 not taken continues", 12'(mem[8'h91]), 12'h7);
      check("R10 taken reaches target", 12'(mem[8'h90]), 12'h8);
      check("R10 no stray fetch", 12'(bad_fetch), 12'h0);
   endtask

   task automatic t_regs_cleared();
      start(1);
      img[8'h90] = 4'hF;
      img[8'h91] = 4'hF;
      load(0, 64'hE90C3E91, 8);
      run(8'h08);
      check("R1 R0 cleared", 12'(mem[8'h90]), 12'h0);
      check("R1 R7 R3 cleared", 12'(mem[8'h91]), 12'h0);
   endtask

   initial begin
      #1_500_000;
      checks++;
      errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      lat = 0;
      for (int i = 0; i < 256; i++) img[i] = 4'h0;
      t_reset();
      t_ldst_wait();
      t_arith();
      t_logic();
      t_shift();
      t_branch();
      t_regs_cleared();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule